// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is an 18-bit first-in first-out buffer. Its write port and its read port run on two clocks, and the two clocks need have no relation to each other. The write port does one of two things, chosen by a load-select input: it queues a data word, or it loads the next programmable register. There are three programmable registers: an almost-empty threshold, an almost-full threshold and a small control word. Five active-low status flags report the fill state: full, almost-full, half-full, almost-empty and empty.

The pointers cross between the clock domains as Gray code, each through two flops. The write domain computes full, almost-full and half-full. The read domain computes empty and almost-empty. A flag can therefore stay pessimistic for a few cycles after the other side moves.

The control word turns on three optional features:
- A second, active-high write enable that two FIFOs can share when they run side by side.
- A matching second read enable.
- A lagged copy of the empty flag, delayed by one read clock, for pipelined cascading.

A strap input sampled during reset decides whether these features start enabled or disabled.

Top module: `fifo_dual_clk`

## Requirements
- R1: Words leave in the order they were accepted. A read happens on a read-clock edge where `rd_en_n` is low and `empty_n` is high. The word appears on `rd_data` after that edge. `rd_data` keeps its value when no read happens, and it is zero after reset.
- R2: While `rst_n` is low the block is in reset, asynchronously. Both pointers return to location 0. Afterwards `full_n`, `almost_full_n` and `half_full_n` are high, and `almost_empty_n`, `empty_n` and `empty_dup_n` are low.
- R3: `almost_empty_n` is low while the fill count is at or below the almost-empty threshold. After reset that threshold is 127.
- R4: `half_full_n` is low while the fill count is greater than half the depth.
- R5: `almost_full_n` is low while the free space is at or below the almost-full threshold. After reset that threshold is 127.
- R6: `full_n` goes low when the FIFO holds DEPTH words. A data write while `full_n` is low is dropped. After a read, `full_n` returns high and the next write is accepted.
- R7: A write with `load_sel` low stores nothing in the FIFO. Successive register writes load the registers in a fixed cycle: almost-empty threshold, then almost-full threshold, then control word, then back to the almost-empty threshold. Thresholds come from `wr_data[ADDR_W-1:0]` and the control word from `wr_data[2:0]`.
- R8: Reset clears every control bit when `mode_strap` is low and sets every control bit when it is high. While control bit 0 is set, a write also needs `wr_en2` high.
- R9: While control bit 1 is set, a read also needs `rd_en2` high.
- R10: While control bit 2 is set, `empty_dup_n` equals `empty_n` delayed by one read clock. While bit 2 is clear, `empty_dup_n` equals `empty_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_strap | input | 1 | Selects the control-word reset value |
| wr_en_n | input | 1 | Write enable, active low |
| wr_en2 | input | 1 | Second write enable, active high, used when control bit 0 is set |
| load_sel | input | 1 | High: write a data word; low: write a register |
| wr_data | input | 18 | Write data or register value |
| rd_en_n | input | 1 | Read enable, active low |
| rd_en2 | input | 1 | Second read enable, active high, used when control bit 1 is set |
| rd_data | output | 18 | Read data |
| full_n | output | 1 | Full flag, active low |
| almost_full_n | output | 1 | Almost-full flag, active low |
| half_full_n | output | 1 | Half-full flag, active low |
| almost_empty_n | output | 1 | Almost-empty flag, active low |
| empty_n | output | 1 | Empty flag, active low |
| empty_dup_n | output | 1 | Empty flag copy, lagged by one read clock when enabled |

## Verification
The checker treats the thresholds and control bits as quasi-static when seen from the read clock. It assumes they change only while the FIFO is idle, so the lagged empty copy can be compared against the previous empty value in every cycle. The stimulus respects this: it writes registers only right after reset or while the buffer is empty and no read is pending. It also issues reads only when `empty_n` is high, or as deliberate probes whose second enable is held low.

// File: rtl/fifo_pkg.sv
// Shared constants and types for the dual-clock FIFO.
package fifo_pkg;
    // Number of implemented control bits.
    localparam int CTRL_W        = 3;
    // Positions of the control bits.
    localparam int CTL_WR_GANG   = 0;
    localparam int CTL_RD_GANG   = 1;
    localparam int CTL_EMPTY_LAG = 2;
    // Reset value of both threshold registers.
    localparam int RESET_OFS     = 127;

    // Which programmable register the next register write loads.
    typedef enum logic [1:0] {
        SEL_AE_OFS = 2'd0,
        SEL_AF_OFS = 2'd1,
        SEL_CTRL   = 2'd2
    } cfg_sel_e;
endpackage

// File: rtl/fifo_cfg_regs.sv
// Programmable thresholds and control word, in the write clock domain.
// Each register write loads the next register in the cycle AE, AF, CTRL.
// Assumes: values are read by the read domain only while they are stable.
module fifo_cfg_regs
    import fifo_pkg::*;
#(
    parameter int ADDR_W = 11,
    localparam int REG_W = (ADDR_W > CTRL_W) ? ADDR_W : CTRL_W
) (
    input  logic              wr_clk,
    input  logic              rst_n,
    input  logic              mode_strap,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_data,
    output logic [ADDR_W-1:0] ae_ofs,
    output logic [ADDR_W-1:0] af_ofs,
    output logic [CTRL_W-1:0] ctrl
);
    cfg_sel_e sel_q;

    // Load the selected register and advance the selection pointer.
    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= SEL_AE_OFS;
            ae_ofs <= ADDR_W'(RESET_OFS);
            af_ofs <= ADDR_W'(RESET_OFS);
            ctrl   <= mode_strap ? '1 : '0;
        end else if (reg_wr) begin
            unique case (sel_q)
                SEL_AE_OFS: begin
                    ae_ofs <= reg_data[ADDR_W-1:0];
                    sel_q  <= SEL_AF_OFS;
                end
                SEL_AF_OFS: begin
                    af_ofs <= reg_data[ADDR_W-1:0];
                    sel_q  <= SEL_CTRL;
                end
                default: begin
                    ctrl  <= reg_data[CTRL_W-1:0];
                    sel_q <= SEL_AE_OFS;
                end
            endcase
        end
    end
endmodule

// File: rtl/fifo_gray_sync.sv
// Two-flop synchroniser for a Gray-coded pointer, followed by a Gray-to-binary decode.
// Assumes: the input comes straight from a register in the source domain and
// changes by at most one bit per source clock.
module fifo_gray_sync #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two-stage resynchronisation into the destination clock.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= gray_in;
            sync_q <= meta_q;
        end
    end

    // Each binary bit is the XOR of all Gray bits at or above it.
    for (genvar i = 0; i < W; i++) begin : g_dec
        assign bin_out[i] = ^sync_q[W-1:i];
    end
endmodule

// File: rtl/fifo_wr_ctl.sv
// Write pointer and the write-domain flags: full, almost-full and half-full.
// The flags are registered from the next-state fill count.
// Assumes: rd_bin is the synchronised read pointer, so the flags may be
// pessimistic by the synchroniser latency.
module fifo_wr_ctl #(
    parameter int ADDR_W = 11,
    localparam int PTR_W = ADDR_W + 1
) (
    input  logic              wr_clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic [PTR_W-1:0]  rd_bin,
    input  logic [ADDR_W-1:0] af_ofs,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [PTR_W-1:0]  wr_gray,
    output logic              push,
    output logic              full_n,
    output logic              almost_full_n,
    output logic              half_full_n
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [PTR_W-1:0] wbin_q;
    logic [PTR_W-1:0] wbin_nxt;
    logic [PTR_W-1:0] fill_nxt;
    logic [PTR_W-1:0] free_nxt;

    // A write request is accepted only while the FIFO is not full.
    assign push     = push_req & full_n;
    assign wbin_nxt = wbin_q + PTR_W'(push);
    assign fill_nxt = wbin_nxt - rd_bin;
    assign free_nxt = PTR_W'(DEPTH) - fill_nxt;
    assign wr_addr  = wbin_q[ADDR_W-1:0];

    // Advance the pointer and register the write-side flags.
    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) begin
            wbin_q        <= '0;
            wr_gray       <= '0;
            full_n        <= 1'b1;
            almost_full_n <= 1'b1;
            half_full_n   <= 1'b1;
        end else begin
            wbin_q        <= wbin_nxt;
            wr_gray       <= wbin_nxt ^ (wbin_nxt >> 1);
            full_n        <= (fill_nxt != PTR_W'(DEPTH));
            almost_full_n <= !(free_nxt <= {1'b0, af_ofs});
            half_full_n   <= !(fill_nxt > PTR_W'(DEPTH / 2));
        end
    end
endmodule

// File: rtl/fifo_rd_ctl.sv
// Read pointer and the read-domain flags: empty, almost-empty and the lagged empty copy.
// Assumes: wr_bin is the synchronised write pointer, and lag_en is quasi-static.
module fifo_rd_ctl #(
    parameter int ADDR_W = 11,
    localparam int PTR_W = ADDR_W + 1
) (
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              pop_req,
    input  logic [PTR_W-1:0]  wr_bin,
    input  logic [ADDR_W-1:0] ae_ofs,
    input  logic              lag_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [PTR_W-1:0]  rd_gray,
    output logic              pop,
    output logic              empty_n,
    output logic              almost_empty_n,
    output logic              empty_dup_n
);
    logic [PTR_W-1:0] rbin_q;
    logic [PTR_W-1:0] rbin_nxt;
    logic [PTR_W-1:0] fill_nxt;
    logic             empty_lag_q;

    // A read request is honoured only while words are present.
    assign pop      = pop_req & empty_n;
    assign rbin_nxt = rbin_q + PTR_W'(pop);
    assign fill_nxt = wr_bin - rbin_nxt;
    assign rd_addr  = rbin_q[ADDR_W-1:0];

    // Advance the pointer and register the read-side flags.
    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            rbin_q         <= '0;
            rd_gray        <= '0;
            empty_n        <= 1'b0;
            almost_empty_n <= 1'b0;
            empty_lag_q    <= 1'b0;
        end else begin
            rbin_q         <= rbin_nxt;
            rd_gray        <= rbin_nxt ^ (rbin_nxt >> 1);
            empty_n        <= (fill_nxt != '0);
            almost_empty_n <= !(fill_nxt <= {1'b0, ae_ofs});
            empty_lag_q    <= empty_n;
        end
    end

    // The copy is lagged by one read clock only when the feature is on.
    assign empty_dup_n = lag_en ? empty_lag_q : empty_n;
endmodule

// File: rtl/fifo_dual_clk.sv
// Top level of the dual-clock FIFO: storage array, enable gating, both
// pointer domains and the configuration registers.
// Assumes: rst_n is asserted before first use; registers are rewritten only while idle.
module fifo_dual_clk
    import fifo_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 11
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              mode_strap,
    input  logic              wr_en_n,
    input  logic              wr_en2,
    input  logic              load_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en_n,
    input  logic              rd_en2,
    output logic [DATA_W-1:0] rd_data,
    output logic              full_n,
    output logic              almost_full_n,
    output logic              half_full_n,
    output logic              almost_empty_n,
    output logic              empty_n,
    output logic              empty_dup_n
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PTR_W = ADDR_W + 1;
    localparam int REG_W = (ADDR_W > CTRL_W) ? ADDR_W : CTRL_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [ADDR_W-1:0] ae_ofs, af_ofs, wr_addr, rd_addr;
    logic [CTRL_W-1:0] ctrl;
    logic [PTR_W-1:0]  wr_gray, rd_gray, wr_bin_rs, rd_bin_ws;
    logic              wr_go, rd_go, push, pop, lag_en;

    // Combine the primary enables with the optional second enables.
    assign wr_go  = !wr_en_n && (!ctrl[CTL_WR_GANG] || wr_en2);
    assign rd_go  = !rd_en_n && (!ctrl[CTL_RD_GANG] || rd_en2);
    assign lag_en = ctrl[CTL_EMPTY_LAG];

    fifo_cfg_regs #(.ADDR_W(ADDR_W)) u_cfg (
        .wr_clk(wr_clk), .rst_n(rst_n), .mode_strap(mode_strap),
        .reg_wr(wr_go && !load_sel), .reg_data(wr_data[REG_W-1:0]),
        .ae_ofs(ae_ofs), .af_ofs(af_ofs), .ctrl(ctrl)
    );

    fifo_wr_ctl #(.ADDR_W(ADDR_W)) u_wr (
        .wr_clk(wr_clk), .rst_n(rst_n), .push_req(wr_go && load_sel),
        .rd_bin(rd_bin_ws), .af_ofs(af_ofs), .wr_addr(wr_addr),
        .wr_gray(wr_gray), .push(push), .full_n(full_n),
        .almost_full_n(almost_full_n), .half_full_n(half_full_n)
    );

    fifo_rd_ctl #(.ADDR_W(ADDR_W)) u_rd (
        .rd_clk(rd_clk), .rst_n(rst_n), .pop_req(rd_go),
        .wr_bin(wr_bin_rs), .ae_ofs(ae_ofs), .lag_en(lag_en),
        .rd_addr(rd_addr), .rd_gray(rd_gray), .pop(pop), .empty_n(empty_n),
        .almost_empty_n(almost_empty_n), .empty_dup_n(empty_dup_n)
    );

    fifo_gray_sync #(.W(PTR_W)) u_w2r (
        .clk(rd_clk), .rst_n(rst_n), .gray_in(wr_gray), .bin_out(wr_bin_rs)
    );

    fifo_gray_sync #(.W(PTR_W)) u_r2w (
        .clk(wr_clk), .rst_n(rst_n), .gray_in(rd_gray), .bin_out(rd_bin_ws)
    );

    // Store accepted data words.
    always_ff @(posedge wr_clk) begin
        if (push) mem_q[wr_addr] <= wr_data;
    end

    // Present the next word on each honoured read.
    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n)   rd_data <= '0;
        else if (pop) rd_data <= mem_q[rd_addr];
    end
endmodule

// File: rtl/fifo_dual_clk_chk.sv
// Temporal checks on the dual-clock FIFO, attached by bind.
// Assumes: the control bits are quasi-static with respect to rd_clk.
module fifo_dual_clk_chk #(
    parameter int DATA_W = 18
) (
    input logic              wr_clk,
    input logic              rd_clk,
    input logic              rst_n,
    input logic              full_n,
    input logic              almost_full_n,
    input logic              half_full_n,
    input logic              almost_empty_n,
    input logic              empty_n,
    input logic              empty_dup_n,
    input logic              lag_en,
    input logic [DATA_W-1:0] rd_data
);
    // R6 with R4: a full FIFO is always more than half full.
    p_full_half_r4: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !full_n |-> !half_full_n);

    // R6 with R5: a full FIFO has no free space, so almost-full holds.
    p_full_af_r5: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !full_n |-> !almost_full_n);

    // R3: an empty FIFO is below any threshold.
    p_empty_ae_r3: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !empty_n |-> !almost_empty_n);

    // R1: no read happens while empty, so the output holds.
    p_hold_empty_r1: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !empty_n |=> $stable(rd_data));

    // R10: the enabled copy trails empty by one read clock.
    p_dup_lag_r10: assert property (@(posedge rd_clk) disable iff (!rst_n)
        lag_en |-> (empty_dup_n == $past(empty_n)));
endmodule

bind fifo_dual_clk fifo_dual_clk_chk #(.DATA_W(DATA_W)) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .full_n(full_n),
    .almost_full_n(almost_full_n), .half_full_n(half_full_n),
    .almost_empty_n(almost_empty_n), .empty_n(empty_n),
    .empty_dup_n(empty_dup_n), .lag_en(lag_en), .rd_data(rd_data)
);

// File: tb/fifo_dual_clk_tb_top.sv
// Scoreboard bench: the write driver queues expected words, and the read monitor pops and compares them.
module fifo_dual_clk_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int RD_PERIOD  = CLK_PERIOD * 7 / 5;
    localparam int DEPTH      = 2048;

    logic        wr_clk = 1'b0, rd_clk = 1'b0;
    logic        rst_n = 1'b0, mode_strap = 1'b0;
    logic        wr_en_n = 1'b1, wr_en2 = 1'b0, load_sel = 1'b1;
    logic [17:0] wr_data = '0;
    logic        rd_en_n = 1'b1, rd_en2 = 1'b0;
    logic [17:0] rd_data;
    logic        full_n, almost_full_n, half_full_n, almost_empty_n, empty_n, empty_dup_n;

    int          n_chk = 0, n_fail = 0, cnt = 0, seq = 0, rd_req = 0;
    bit          probe_req = 0;
    logic [17:0] exp_q[$];

    always #(CLK_PERIOD / 2) wr_clk = ~wr_clk;
    always #(RD_PERIOD / 2) rd_clk = ~rd_clk;

    fifo_dual_clk dut_i (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .mode_strap(mode_strap),
        .wr_en_n(wr_en_n), .wr_en2(wr_en2), .load_sel(load_sel), .wr_data(wr_data),
        .rd_en_n(rd_en_n), .rd_en2(rd_en2), .rd_data(rd_data), .full_n(full_n),
        .almost_full_n(almost_full_n), .half_full_n(half_full_n),
        .almost_empty_n(almost_empty_n), .empty_n(empty_n), .empty_dup_n(empty_dup_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    function automatic logic [17:0] pat(input int i);
        if (i % 3 == 0) return 18'(1 << (i % 18));
        if (i % 3 == 1) return 18'(i * 37) ^ 18'h15A5;
        return (i % 2 == 0) ? 18'h2AAAA : 18'h15555;
    endfunction

    task automatic do_reset(input logic strap);
        rst_n = 1'b0; mode_strap = strap; wr_en_n = 1'b1; load_sel = 1'b1;
        exp_q.delete(); cnt = 0; rd_req = 0;
        repeat (3) @(negedge wr_clk);
        rst_n = 1'b1;
        repeat (2) @(negedge wr_clk);
    endtask

    // Driver: one write attempt; the word is queued only when acceptance is predicted.
    task automatic write_word(input logic [17:0] d, input bit accept);
        @(negedge wr_clk);
        wr_en_n = 1'b0; load_sel = 1'b1; wr_data = d;
        @(negedge wr_clk);
        wr_en_n = 1'b1;
        if (accept) begin exp_q.push_back(d); cnt++; end
    endtask

    task automatic write_reg(input logic [17:0] v);
        @(negedge wr_clk);
        wr_en_n = 1'b0; load_sel = 1'b0; wr_data = v;
        @(negedge wr_clk);
        wr_en_n = 1'b1; load_sel = 1'b1;
    endtask

    task automatic fill_to(input int target);
        while (cnt < target) begin write_word(pat(seq), 1'b1); seq++; end
    endtask

    task automatic settle;
        repeat (8) @(negedge rd_clk);
        repeat (8) @(negedge wr_clk);
    endtask

    task automatic drain_all;
        rd_req = cnt;
        wait (rd_req == 0);
        settle();
    endtask

    // Monitor: performs the requested reads and compares each one with the queue head.
    initial begin
        forever begin
            @(negedge rd_clk);
            if (probe_req) begin
                rd_en_n = 1'b0;
                repeat (3) @(negedge rd_clk);
                rd_en_n = 1'b1;
                probe_req = 0;
            end else if (rd_req > 0 && empty_n) begin
                rd_en_n = 1'b0;
                @(negedge rd_clk);
                rd_en_n = 1'b1;
                if (exp_q.size() == 0) check(1'b0, "R1 unexpected word", rd_data, 0);
                else begin
                    logic [17:0] e;
                    e = exp_q.pop_front();
                    check(rd_data == e, "R1 order", rd_data, e);
                end
                cnt--; rd_req--;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge wr_clk);
        check(1'b0, "watchdog", 0, 1);
        report();
    end

    initial begin
        // Strap low: control word zero, so the second enables held low have no effect (R8).
        do_reset(1'b0);
        check(full_n && almost_full_n && half_full_n, "R2 write flags", {full_n, almost_full_n, half_full_n}, 3'b111);
        check(!almost_empty_n && !empty_n && !empty_dup_n, "R2 read flags", {almost_empty_n, empty_n, empty_dup_n}, 0);
        check(rd_data == 0, "R1 reset data", rd_data, 0);

        write_word(pat(seq), 1'b1); seq++;
        for (int k = 0; k < 30 && !empty_n; k++) @(negedge rd_clk);
        check(empty_n == 1'b1, "R8 write with wr_en2 low, ctrl clear", empty_n, 1);
        check(empty_dup_n == empty_n, "R10 copy unlagged", empty_dup_n, empty_n);
        fill_to(20);
        drain_all();
        check(!empty_n && exp_q.size() == 0, "R1 drained", empty_n, 0);

        // Default thresholds and the full boundary.
        fill_to(127);  settle(); check(!almost_empty_n, "R3 fill 127", almost_empty_n, 0);
        fill_to(128);  settle(); check(almost_empty_n, "R3 fill 128", almost_empty_n, 1);
        fill_to(1024); settle(); check(half_full_n, "R4 fill 1024", half_full_n, 1);
        fill_to(1025); settle(); check(!half_full_n, "R4 fill 1025", half_full_n, 0);
        fill_to(1920); settle(); check(almost_full_n, "R5 free 128", almost_full_n, 1);
        fill_to(1921); settle(); check(!almost_full_n, "R5 free 127", almost_full_n, 0);
        fill_to(2047); settle(); check(full_n, "R6 one free", full_n, 1);
        fill_to(DEPTH); settle(); check(!full_n, "R6 full", full_n, 0);
        write_word(18'h3ABCD, 1'b0);
        rd_req = 1; wait (rd_req == 0); settle();
        check(full_n, "R6 released after read", full_n, 1);
        write_word(pat(seq), 1'b1); seq++;
        settle(); check(!full_n, "R6 refilled", full_n, 0);
        drain_all();
        check(!empty_n && exp_q.size() == 0, "R6 dropped word absent", exp_q.size(), 0);

        // Programmed thresholds.
        do_reset(1'b0);
        write_reg(18'd5); write_reg(18'd10); write_reg(18'd0);
        settle(); check(!empty_n, "R7 register writes not queued", empty_n, 0);
        fill_to(5);    settle(); check(!almost_empty_n, "R7 ae at 5", almost_empty_n, 0);
        fill_to(6);    settle(); check(almost_empty_n, "R7 ae at 6", almost_empty_n, 1);
        fill_to(2037); settle(); check(almost_full_n, "R7 free 11", almost_full_n, 1);
        fill_to(2038); settle(); check(!almost_full_n, "R7 free 10", almost_full_n, 0);
        drain_all();

        // Strap high: every enhanced feature on.
        do_reset(1'b1);
        wr_en2 = 1'b0; rd_en2 = 1'b1;
        write_word(18'h01234, 1'b0);
        settle(); check(!empty_n, "R8 wr_en2 low blocks", empty_n, 0);
        wr_en2 = 1'b1;
        write_word(18'h05678, 1'b1);
        for (int k = 0; k < 30 && !empty_n; k++) @(negedge rd_clk);
        check(empty_n && !empty_dup_n, "R10 copy still empty", empty_dup_n, 0);
        @(negedge rd_clk);
        check(empty_dup_n, "R10 copy one clock later", empty_dup_n, 1);
        rd_en2 = 1'b0; probe_req = 1; wait (!probe_req); settle();
        check(empty_n, "R9 rd_en2 low blocks", empty_n, 1);
        rd_en2 = 1'b1;
        drain_all();
        check(!empty_n, "R9 read with rd_en2 high", empty_n, 0);

        // Clear the control word; the second write enable no longer matters.
        write_reg(18'd127); write_reg(18'd127); write_reg(18'd0);
        wr_en2 = 1'b0;
        write_word(18'h0BEEF, 1'b1);
        settle(); check(empty_n, "R7 control cleared", empty_n, 1);
        drain_all();
        check(exp_q.size() == 0, "R1 final queue", exp_q.size(), 0);
        report();
    end
endmodule